// File: doc/BRIEF.md
# Self-Invalidating L1 Word State Tracker

This block holds the coherence state of every word in a small private first-level data array. The protocol it serves has no directory and sends no invalidations. A writer claims ownership by registering with the shared level. A reader removes stale copies itself, in one of two ways: a sweep at each parallel-phase boundary, or a filtered check on atomic loads inside a critical section.

Each accepted request produces a response one cycle later. A read miss also raises a fill request, and a write to a word with no registration in flight also raises a registration request, both in that same response cycle. An external signature filter answers on `sig_hit` in the cycle a request is accepted. It reports whether the request address may have been written under a lock by another core. A per-word touched bit records that an atomic load has already been checked in the current critical section.

Top module: `swst_tracker`

## Requirements
- R1: After reset every word is Invalid (state code 2'b00), no touched bit and no registration is outstanding, and `busy`, `resp_valid`, `miss_req_valid` and `reg_req_valid` are low.
- R2: A read of an Invalid word is accepted as a miss. One cycle after acceptance `resp_valid` is 1 with `resp_hit` 0, and `miss_req_valid` is 1 with the word address on `miss_req_addr`. The word stays Invalid until a fill arrives.
- R3: A `fill_valid` pulse for an Invalid word makes it Valid (2'b01), so a later plain read hits.
- R4: A write from any state makes the word Registered (2'b10) and responds with `resp_hit` 1. If no registration is outstanding for that word, the write also raises `reg_req_valid` with the word address on `reg_req_addr` in the response cycle.
- R5: A registration stays outstanding until `reg_ack` names the word. Writes to the word in the meantime raise no further request. The first write after the acknowledge raises one again.
- R6: A `phase_end` pulse starts a sweep. `busy` is high for exactly NWORDS cycles, from the cycle after the pulse. Afterwards every word that was Valid is Invalid and every Registered word is still Registered.
- R7: No request is accepted while `busy` is high. A request held during the sweep is answered only after `busy` has dropped.
- R8: An atomic load of a Valid, untouched word with `sig_hit` 1 invalidates the word and is answered as a miss with a fill request.
- R9: An atomic load of a Valid, untouched word with `sig_hit` 0 hits and leaves the word Valid.
- R10: A load of a Registered word always hits, whatever `sig_hit` and the atomic tag are.
- R11: The first atomic load of a word sets its touched bit. Later atomic loads of that word skip the filter check and hit when the word is Valid, even with `sig_hit` 1.
- R12: A `cs_enter` pulse clears every touched bit, so the next atomic load consults the filter again.
- R13: A non-atomic load never consults the filter: it hits on a Valid word even with `sig_hit` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_write | input | 1 | 1 = store, 0 = load |
| req_atomic | input | 1 | Access belongs to an atomic region |
| req_addr | input | $clog2(NWORDS) | Word index of the request |
| sig_hit | input | 1 | Signature filter answer for `req_addr` |
| phase_end | input | 1 | Parallel-phase boundary pulse |
| cs_enter | input | 1 | Lock acquired, critical section starts |
| fill_valid | input | 1 | Fill data returned for `fill_addr` |
| fill_addr | input | $clog2(NWORDS) | Word index of the fill |
| reg_ack | input | 1 | Registration acknowledged for `reg_ack_addr` |
| reg_ack_addr | input | $clog2(NWORDS) | Word index of the acknowledge |
| busy | output | 1 | Self-invalidation sweep in progress |
| resp_valid | output | 1 | Response to the request accepted last cycle |
| resp_hit | output | 1 | Response is a hit |
| miss_req_valid | output | 1 | Read-miss request to the shared level |
| miss_req_addr | output | $clog2(NWORDS) | Word index of the read miss |
| reg_req_valid | output | 1 | Registration request to the shared level |
| reg_req_addr | output | $clog2(NWORDS) | Word index to register |

## Verification
Loads are driven in each combination of word state, atomic tag, touched bit and filter answer. This separates the four cases: a Registered word that bypasses the filter, a plain load that ignores it, a first atomic load that obeys it, and a touched word that skips it. Repeated writes with and without an acknowledge in between show that registration requests are suppressed only while one is outstanding. A sweep started with a mix of Valid and Registered words shows both that Valid words are removed and Registered words are kept. A request held across a sweep shows the stall.

// File: rtl/swst_pkg.sv
package swst_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'b00,
    ST_VAL = 2'b01,
    ST_REG = 2'b10
  } word_st_e;
endpackage

// File: rtl/swst_sweep.sv
module swst_sweep #(
  parameter int NWORDS = 16,
  localparam int IW = $clog2(NWORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [IW-1:0] idx
);
  logic          busy_q, busy_n;
  logic [IW-1:0] cnt_q, cnt_n;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        cnt_n  = '0;
      end
    end else if (cnt_q == IW'(NWORDS - 1)) begin
      busy_n = 1'b0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy = busy_q;
  assign idx  = cnt_q;

  p_sweep_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> (busy_q && cnt_q == '0));
  p_sweep_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == IW'(NWORDS - 1)) |=> !busy_q);
endmodule

// File: rtl/swst_word.sv
module swst_word
  import swst_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic     kill_en,
  input  logic     fill_en,
  input  logic     sweep_en,
  input  logic     touch_set,
  input  logic     touch_clr,
  input  logic     ack_en,
  output word_st_e st_o,
  output logic     touched_o,
  output logic     pend_o
);
  word_st_e st_q, st_n;
  logic     tch_q, tch_n;
  logic     pnd_q, pnd_n;

  always_comb begin
    st_n = st_q;
    if (wr_en)                           st_n = ST_REG;
    else if (kill_en)                    st_n = ST_INV;
    else if (fill_en && st_q == ST_INV)  st_n = ST_VAL;
    else if (sweep_en && st_q == ST_VAL) st_n = ST_INV;

    tch_n = touch_clr ? 1'b0 : tch_q;
    if (touch_set) tch_n = 1'b1;

    pnd_n = pnd_q;
    if (wr_en && !pnd_q) pnd_n = 1'b1;
    else if (ack_en)     pnd_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_INV;
      tch_q <= 1'b0;
      pnd_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      tch_q <= tch_n;
      pnd_q <= pnd_n;
    end
  end

  assign st_o      = st_q;
  assign touched_o = tch_q;
  assign pend_o    = pnd_q;

  p_write_registers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (st_q == ST_REG));
  p_sweep_keeps_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_en && st_q == ST_REG) |=> (st_q == ST_REG));
  p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pnd_q && !ack_en) |=> pnd_q);
  p_touch_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_clr && !touch_set) |=> !tch_q);
endmodule

// File: rtl/swst_tracker.sv
module swst_tracker
  import swst_pkg::*;
#(
  parameter int NWORDS = 16,
  localparam int IW = $clog2(NWORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_atomic,
  input  logic [IW-1:0] req_addr,
  input  logic          sig_hit,
  input  logic          phase_end,
  input  logic          cs_enter,
  input  logic          fill_valid,
  input  logic [IW-1:0] fill_addr,
  input  logic          reg_ack,
  input  logic [IW-1:0] reg_ack_addr,
  output logic          busy,
  output logic          resp_valid,
  output logic          resp_hit,
  output logic          miss_req_valid,
  output logic [IW-1:0] miss_req_addr,
  output logic          reg_req_valid,
  output logic [IW-1:0] reg_req_addr
);
  logic          sw_busy;
  logic [IW-1:0] sw_idx;
  word_st_e      st_arr  [NWORDS];
  logic          tch_arr [NWORDS];
  logic          pnd_arr [NWORDS];

  logic     acc, is_rd, chk_kill, rd_hit;
  word_st_e cur_st;

  swst_sweep #(.NWORDS(NWORDS)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(phase_end), .busy(sw_busy), .idx(sw_idx)
  );

  always_comb begin
    acc      = req_valid && !sw_busy;
    is_rd    = acc && !req_write;
    cur_st   = st_arr[req_addr];
    chk_kill = is_rd && req_atomic && cur_st == ST_VAL &&
               !tch_arr[req_addr] && sig_hit;
    rd_hit   = (cur_st == ST_REG) || (cur_st == ST_VAL && !chk_kill);
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic wsel;
    assign wsel = (req_addr == IW'(w));
    swst_word u_word (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (acc && req_write && wsel),
      .kill_en   (chk_kill && wsel),
      .fill_en   (fill_valid && fill_addr == IW'(w)),
      .sweep_en  (sw_busy && sw_idx == IW'(w)),
      .touch_set (is_rd && req_atomic && wsel),
      .touch_clr (cs_enter),
      .ack_en    (reg_ack && reg_ack_addr == IW'(w)),
      .st_o      (st_arr[w]),
      .touched_o (tch_arr[w]),
      .pend_o    (pnd_arr[w])
    );
  end

  logic          rv_n, rh_n, mv_n, gv_n;
  logic          rv_q, rh_q, mv_q, gv_q;
  logic [IW-1:0] ma_q, ga_q;

  always_comb begin
    rv_n = acc;
    rh_n = req_write || rd_hit;
    mv_n = is_rd && !rd_hit;
    gv_n = acc && req_write && !pnd_arr[req_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rh_q <= 1'b0;
      mv_q <= 1'b0;
      gv_q <= 1'b0;
      ma_q <= '0;
      ga_q <= '0;
    end else begin
      rv_q <= rv_n;
      rh_q <= rh_n;
      mv_q <= mv_n;
      gv_q <= gv_n;
      if (mv_n) ma_q <= req_addr;
      if (gv_n) ga_q <= req_addr;
    end
  end

  assign busy           = sw_busy;
  assign resp_valid     = rv_q;
  assign resp_hit       = rh_q;
  assign miss_req_valid = mv_q;
  assign miss_req_addr  = ma_q;
  assign reg_req_valid  = gv_q;
  assign reg_req_addr   = ga_q;

  p_miss_is_read_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req_valid |-> (resp_valid && !resp_hit));
  p_reg_with_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_valid |-> (resp_valid && resp_hit));
  p_stall_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !resp_valid);
  p_reg_word_hits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cur_st == ST_REG) |=> (resp_valid && resp_hit));
endmodule

// File: tb/swst_tracker_test.sv
`timescale 1ns/1ps
module swst_tracker_test;
  localparam int NW = 16;
  localparam int IW = $clog2(NW);

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_atomic, sig_hit;
  logic [IW-1:0] req_addr, fill_addr, reg_ack_addr;
  logic phase_end, cs_enter, fill_valid, reg_ack;
  logic busy, resp_valid, resp_hit, miss_req_valid, reg_req_valid;
  logic [IW-1:0] miss_req_addr, reg_req_addr;

  always #2.5 clk = ~clk;

  swst_tracker #(.NWORDS(NW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_atomic(req_atomic), .req_addr(req_addr), .sig_hit(sig_hit),
    .phase_end(phase_end), .cs_enter(cs_enter), .fill_valid(fill_valid),
    .fill_addr(fill_addr), .reg_ack(reg_ack), .reg_ack_addr(reg_ack_addr),
    .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .miss_req_valid(miss_req_valid), .miss_req_addr(miss_req_addr),
    .reg_req_valid(reg_req_valid), .reg_req_addr(reg_req_addr)
  );

  typedef struct packed {
    logic          hit;
    logic          mreq;
    logic          rreq;
    logic [IW-1:0] addr;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  logic  prev_busy = 1'b0;
  bit    done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected response", 1, 0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(resp_hit == e.hit, t, "resp_hit", resp_hit, e.hit);
        check(miss_req_valid == e.mreq && (!e.mreq || miss_req_addr == e.addr),
              t, "miss request", {miss_req_valid, miss_req_addr}, {e.mreq, e.addr});
        check(reg_req_valid == e.rreq && (!e.rreq || reg_req_addr == e.addr),
              t, "registration request", {reg_req_valid, reg_req_addr}, {e.rreq, e.addr});
        check(!prev_busy, "R7", "accepted while busy", prev_busy, 0);
      end
    end
    prev_busy = busy;
  end

  // driver: one request, waits out a sweep, records what must come back
  task automatic do_req(input bit wr, input bit at, input int a, input bit sh,
                        input bit hit, input bit rreq, input string tag);
    exp_t e;
    req_valid = 1'b1; req_write = wr; req_atomic = at;
    req_addr = IW'(a); sig_hit = sh;
    while (busy) @(negedge clk);
    e.hit = hit; e.mreq = !wr && !hit; e.rreq = rreq; e.addr = IW'(a);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0; sig_hit = 1'b0;
  endtask

  task automatic rd(input bit at, input int a, input bit sh, input bit hit,
                    input string tag);
    do_req(1'b0, at, a, sh, hit, 1'b0, tag);
  endtask

  task automatic fill(input int a);
    fill_valid = 1'b1; fill_addr = IW'(a);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic ack(input int a);
    reg_ack = 1'b1; reg_ack_addr = IW'(a);
    @(negedge clk);
    reg_ack = 1'b0;
  endtask

  task automatic pulse_cs();
    cs_enter = 1'b1;
    @(negedge clk);
    cs_enter = 1'b0;
  endtask

  task automatic pulse_phase();
    phase_end = 1'b1;
    @(negedge clk);
    phase_end = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2", "responses missing", exp_q.size(), 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      check(1'b0, "R1", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    bit r7_bad;
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_atomic = 0; req_addr = '0; sig_hit = 0;
    phase_end = 0; cs_enter = 0; fill_valid = 0; fill_addr = '0;
    reg_ack = 0; reg_ack_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset
    check(!busy && !resp_valid && !miss_req_valid && !reg_req_valid, "R1",
          "outputs after reset", {busy, resp_valid, miss_req_valid, reg_req_valid}, 0);
    rd(0, 2, 0, 0, "R1");
    rd(0, 2, 0, 0, "R2");
    fill(2);
    rd(0, 2, 0, 1, "R3");
    // R4 / R5: registration and its suppression
    do_req(1, 0, 3, 0, 1, 1, "R4");
    do_req(1, 0, 3, 0, 1, 0, "R5");
    ack(3);
    do_req(1, 0, 3, 0, 1, 1, "R5");
    ack(3);
    do_req(1, 0, 2, 0, 1, 1, "R4");
    ack(2);
    fill(5);
    rd(0, 5, 1, 1, "R13");
    settle();
    // R6: sweep length and effect
    pulse_phase();
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check(cnt == NW, "R6", "busy cycles", cnt, NW);
    rd(0, 5, 0, 0, "R6");
    rd(0, 3, 0, 1, "R6");
    rd(0, 2, 0, 1, "R6");
    settle();
    // R7: request held across a sweep
    pulse_phase();
    r7_bad = 1'b0;
    fork
      rd(0, 3, 0, 1, "R7");
      begin
        while (busy) begin
          if (resp_valid) r7_bad = 1'b1;
          @(negedge clk);
        end
      end
    join
    check(!r7_bad, "R7", "response during sweep", r7_bad, 0);
    settle();
    // R8 / R11: filtered atomic load, then touched word skips the check
    fill(5);
    rd(1, 5, 1, 0, "R8");
    rd(0, 5, 0, 0, "R8");
    fill(5);
    rd(1, 5, 1, 1, "R11");
    // R9 / R11
    fill(6);
    rd(1, 6, 0, 1, "R9");
    rd(1, 6, 1, 1, "R11");
    // R10: registered word ignores the filter
    rd(1, 2, 1, 1, "R10");
    settle();
    // R12: new critical section re-arms the check
    pulse_cs();
    rd(1, 6, 1, 0, "R12");
    rd(1, 3, 1, 1, "R10");
    settle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule